// File: doc/BRIEF.md
# Escape Opcode Decoder

This block sits at the front of a byte-coded stack machine's instruction path. It takes one instruction at a time, as an opcode byte, the byte after it and the address of the opcode, and sorts it. An opcode that is not special is reported as handled elsewhere. Two opcodes are escapes: they read the following byte as a sub-opcode and turn it into a dispatch index. Sub-opcodes with no operation behind them become an escape trap. A fixed list of single-byte opcodes that are not implemented becomes an opcode trap.

The sub-opcode is decoded in two levels. Its high nibble names a group of sixteen. Six groups are live, and the other ten trap as a whole. A few single codes inside live groups also trap. Every trap carries a parameter and a program counter that the trap handler uses to resume or report. The result appears a fixed two cycles after the input strobe, with a one-cycle done pulse. It then holds until the next result.

Top module: `esc_dispatch_decoder`

## Requirements
- R1: Opcodes 0xF8 and 0xF9 are both escapes. Both take `in_operand` as the sub-opcode and decode it in exactly the same way.
- R2: An escape whose sub-opcode high nibble is 3, 4, 5, 6 or A to F always gives an escape trap.
- R3: An escape with sub-opcode 0x00, 0x01, 0x2C, 0x2D, 0x2E, 0x7F or 0x83 gives an escape trap, even though its group (0, 1, 2, 7, 8 or 9) is otherwise live.
- R4: The parameter of an escape trap is 0x100 plus the sub-opcode (9 bits wide).
- R5: On an escape trap, `out_pc` is `in_pc` + 1, modulo 2^PC_W. This is the address just past the escape opcode.
- R6: Opcodes 0x3E, 0x3F, 0x7D, 0x7E, 0x7F, 0xBF and 0xFA to 0xFE give an opcode trap. Its parameter is the opcode, zero-extended, and `out_pc` equals `in_pc`.
- R7: `trap_kind` is 0 for an escape trap and 1 for an opcode trap.
- R8: An escape that does not trap gives `out_kind` = 2'b01, `out_index` = sub-opcode, `out_pc` = `in_pc` + 2 and `trap_req` = 0. A trap gives `out_kind` = 2'b11 with `trap_req` = 1, and `out_index` = 0.
- R9: Any other opcode gives `out_kind` = 2'b10, `trap_req` = 0, `out_index` = 0, `trap_param` = 0 and `out_pc` = `in_pc`.
- R10: `out_done` pulses for one cycle exactly two rising edges after the edge that samples `in_valid`. All result outputs hold their values between done pulses. Strobes in back-to-back cycles each give their own result.
- R11: A synchronous active-high `rst` clears every output to zero (`out_kind` = 2'b00) and drops any instruction still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction strobe |
| in_opcode | input | 8 | Opcode byte |
| in_operand | input | 8 | Byte following the opcode |
| in_pc | input | PC_W | Address of the opcode |
| out_done | output | 1 | One-cycle result pulse |
| out_kind | output | 2 | 00 none, 01 dispatch, 10 elsewhere, 11 trap |
| out_index | output | 8 | Dispatch index |
| trap_req | output | 1 | Trap requested |
| trap_kind | output | 1 | 0 escape trap, 1 opcode trap |
| trap_param | output | 9 | Trap parameter |
| out_pc | output | PC_W | Corrected program counter |

## Verification
The bench drives every in-group hole and the first and last codes of the trapping groups. A decoder that tests only the group nibble would dispatch the holes, and one that tests only the hole list would dispatch whole dead groups. It sends both escape opcodes and 0xF7, 0xFF and 0xFA at the edges of the escape encoding, where an off-by-one range would misclassify them. It uses addresses that wrap at 0xFFFF to catch a PC adjustment of the wrong size or direction. Back-to-back strobes and a reset in mid-flight expose results that are lost, duplicated or late.

// File: rtl/esc_pkg.sv
package esc_pkg;

  localparam int unsigned OP_W        = 8;
  localparam int unsigned TRAP_ARG_W  = OP_W + 1;
  localparam logic [OP_W-1:0] ESC_OP_0 = 8'o370;
  localparam logic [OP_W-1:0] ESC_OP_1 = 8'o371;

  typedef enum logic [1:0] {
    RK_NONE     = 2'b00,
    RK_DISPATCH = 2'b01,
    RK_ELSEWHERE= 2'b10,
    RK_TRAP     = 2'b11
  } res_kind_e;

  // Groups (high nibble of sub-opcode) that are decoded further
  function automatic logic group_live(input logic [3:0] grp);
    case (grp)
      4'h0, 4'h1, 4'h2, 4'h7, 4'h8, 4'h9: group_live = 1'b1;
      default:                            group_live = 1'b0;
    endcase
  endfunction

  // Holes inside live groups
  function automatic logic sub_hole(input logic [OP_W-1:0] sub);
    case (sub)
      8'h00, 8'h01, 8'h2C, 8'h2D, 8'h2E, 8'h7F, 8'h83: sub_hole = 1'b1;
      default:                                          sub_hole = 1'b0;
    endcase
  endfunction

  function automatic logic is_escape(input logic [OP_W-1:0] op);
    is_escape = (op == ESC_OP_0) || (op == ESC_OP_1);
  endfunction

  // Single-byte opcodes without implementation
  function automatic logic single_unimp(input logic [OP_W-1:0] op);
    case (op)
      8'o076, 8'o077, 8'o175, 8'o176, 8'o177, 8'o277,
      8'o372, 8'o373, 8'o374, 8'o375, 8'o376: single_unimp = 1'b1;
      default:                                single_unimp = 1'b0;
    endcase
  endfunction

  function automatic logic [TRAP_ARG_W-1:0] esc_trap_arg(input logic [OP_W-1:0] sub);
    esc_trap_arg = {1'b1, sub};
  endfunction

  function automatic logic [TRAP_ARG_W-1:0] op_trap_arg(input logic [OP_W-1:0] op);
    op_trap_arg = {1'b0, op};
  endfunction

endpackage

// File: rtl/esc_capture.sv
module esc_capture
  import esc_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_opcode,
  input  logic [OP_W-1:0] in_operand,
  input  logic [PC_W-1:0] in_pc,
  output logic            cap_vld,
  output logic [OP_W-1:0] cap_op,
  output logic [OP_W-1:0] cap_arg,
  output logic [PC_W-1:0] cap_pc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld <= 1'b0;
      cap_op  <= '0;
      cap_arg <= '0;
      cap_pc  <= '0;
    end else begin
      cap_vld <= in_valid;
      if (in_valid) begin
        cap_op  <= in_opcode;
        cap_arg <= in_operand;
        cap_pc  <= in_pc;
      end
    end
  end

endmodule

// File: rtl/esc_classify.sv
module esc_classify
  import esc_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic [OP_W-1:0]       op,
  input  logic [OP_W-1:0]       arg,
  input  logic [PC_W-1:0]       pc,
  output res_kind_e             kind,
  output logic                  trap,
  output logic                  tkind,
  output logic [OP_W-1:0]       idx,
  output logic [TRAP_ARG_W-1:0] param,
  output logic [PC_W-1:0]       pc_nx,
  output logic                  ev_esc,
  output logic                  ev_hole,
  output logic                  ev_group_dead,
  output logic                  ev_unimp
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);
  localparam logic [PC_W-1:0] PC_TWO = PC_W'(2);

  assign ev_esc        = is_escape(op);
  assign ev_group_dead = ev_esc && !group_live(arg[OP_W-1:OP_W-4]);
  assign ev_hole       = ev_esc && group_live(arg[OP_W-1:OP_W-4]) && sub_hole(arg);
  assign ev_unimp      = !ev_esc && single_unimp(op);

  always_comb begin
    kind  = RK_ELSEWHERE;
    trap  = 1'b0;
    tkind = 1'b0;
    idx   = '0;
    param = '0;
    pc_nx = pc;
    if (ev_esc) begin
      if (ev_group_dead || ev_hole) begin
        kind  = RK_TRAP;
        trap  = 1'b1;
        tkind = 1'b0;
        param = esc_trap_arg(arg);
        pc_nx = pc + PC_ONE;
      end else begin
        kind  = RK_DISPATCH;
        idx   = arg;
        pc_nx = pc + PC_TWO;
      end
    end else if (ev_unimp) begin
      kind  = RK_TRAP;
      trap  = 1'b1;
      tkind = 1'b1;
      param = op_trap_arg(op);
    end
  end

endmodule

// File: rtl/esc_result_reg.sv
module esc_result_reg
  import esc_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  res_kind_e             kind_d,
  input  logic                  trap_d,
  input  logic                  tkind_d,
  input  logic [OP_W-1:0]       idx_d,
  input  logic [TRAP_ARG_W-1:0] param_d,
  input  logic [PC_W-1:0]       pc_d,
  output logic                  done_q,
  output res_kind_e             kind_q,
  output logic                  trap_q,
  output logic                  tkind_q,
  output logic [OP_W-1:0]       idx_q,
  output logic [TRAP_ARG_W-1:0] param_q,
  output logic [PC_W-1:0]       pc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      kind_q  <= RK_NONE;
      trap_q  <= 1'b0;
      tkind_q <= 1'b0;
      idx_q   <= '0;
      param_q <= '0;
      pc_q    <= '0;
    end else begin
      done_q <= load;
      if (load) begin
        kind_q  <= kind_d;
        trap_q  <= trap_d;
        tkind_q <= tkind_d;
        idx_q   <= idx_d;
        param_q <= param_d;
        pc_q    <= pc_d;
      end
    end
  end

endmodule

// File: rtl/esc_dispatch_decoder.sv
module esc_dispatch_decoder
  import esc_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            in_opcode,
  input  logic [7:0]            in_operand,
  input  logic [PC_W-1:0]       in_pc,
  output logic                  out_done,
  output logic [1:0]            out_kind,
  output logic [7:0]            out_index,
  output logic                  trap_req,
  output logic                  trap_kind,
  output logic [8:0]            trap_param,
  output logic [PC_W-1:0]       out_pc
);

  // Named internal events, observed by the bound checker
  logic                  stage_vld;
  logic [OP_W-1:0]       stage_op;
  logic [OP_W-1:0]       stage_arg;
  logic [PC_W-1:0]       stage_pc;
  res_kind_e             cls_kind;
  logic                  cls_trap;
  logic                  cls_tkind;
  logic [OP_W-1:0]       cls_idx;
  logic [TRAP_ARG_W-1:0] cls_param;
  logic [PC_W-1:0]       cls_pc;
  logic                  ev_esc;
  logic                  ev_hole;
  logic                  ev_group_dead;
  logic                  ev_unimp;
  res_kind_e             kind_q;

  esc_capture #(.PC_W(PC_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_opcode  (in_opcode),
    .in_operand (in_operand),
    .in_pc      (in_pc),
    .cap_vld    (stage_vld),
    .cap_op     (stage_op),
    .cap_arg    (stage_arg),
    .cap_pc     (stage_pc)
  );

  esc_classify #(.PC_W(PC_W)) u_cls (
    .op            (stage_op),
    .arg           (stage_arg),
    .pc            (stage_pc),
    .kind          (cls_kind),
    .trap          (cls_trap),
    .tkind         (cls_tkind),
    .idx           (cls_idx),
    .param         (cls_param),
    .pc_nx         (cls_pc),
    .ev_esc        (ev_esc),
    .ev_hole       (ev_hole),
    .ev_group_dead (ev_group_dead),
    .ev_unimp      (ev_unimp)
  );

  esc_result_reg #(.PC_W(PC_W)) u_res (
    .clk     (clk),
    .rst     (rst),
    .load    (stage_vld),
    .kind_d  (cls_kind),
    .trap_d  (cls_trap),
    .tkind_d (cls_tkind),
    .idx_d   (cls_idx),
    .param_d (cls_param),
    .pc_d    (cls_pc),
    .done_q  (out_done),
    .kind_q  (kind_q),
    .trap_q  (trap_req),
    .tkind_q (trap_kind),
    .idx_q   (out_index),
    .param_q (trap_param),
    .pc_q    (out_pc)
  );

  assign out_kind = kind_q;

endmodule

// File: rtl/esc_dispatch_chk.sv
module esc_dispatch_chk #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [7:0]      in_opcode,
  input logic [7:0]      in_operand,
  input logic [PC_W-1:0] in_pc,
  input logic            stage_vld,
  input logic            ev_hole,
  input logic            ev_group_dead,
  input logic            out_done,
  input logic [1:0]      out_kind,
  input logic [7:0]      out_index,
  input logic            trap_req,
  input logic            trap_kind,
  input logic [8:0]      trap_param,
  input logic [PC_W-1:0] out_pc
);

  a_r10_capture: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> stage_vld);

  a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
    stage_vld |=> out_done);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !stage_vld |=> !out_done);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_done && !$past(rst)) |->
      ($stable(out_kind) && $stable(out_pc) && $stable(trap_param) &&
       $stable(trap_req) && $stable(out_index)));

  a_r3_hole_traps: assert property (@(posedge clk) disable iff (rst)
    (stage_vld && (ev_hole || ev_group_dead)) |=> (trap_req && !trap_kind));

  a_r8_trap_flag: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (trap_req == (out_kind == 2'b11)));

  a_r4_esc_param: assert property (@(posedge clk) disable iff (rst)
    (out_done && trap_req && !trap_kind) |->
      (trap_param == {1'b1, $past(in_operand, 2)}));

  a_r5_esc_pc: assert property (@(posedge clk) disable iff (rst)
    (out_done && trap_req && !trap_kind) |->
      (out_pc == $past(in_pc, 2) + PC_W'(1)));

  a_r6_op_trap: assert property (@(posedge clk) disable iff (rst)
    (out_done && trap_req && trap_kind) |->
      (trap_param == {1'b0, $past(in_opcode, 2)} && out_pc == $past(in_pc, 2)));

  a_r1_dispatch_src: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_kind == 2'b01) |->
      (($past(in_opcode, 2) == 8'hF8 || $past(in_opcode, 2) == 8'hF9) &&
       out_index == $past(in_operand, 2)));

  a_r11_reset: assert property (@(posedge clk)
    rst |=> (out_kind == 2'b00 && !trap_req && !out_done && !stage_vld &&
             out_pc == '0 && trap_param == '0));

endmodule

bind esc_dispatch_decoder esc_dispatch_chk #(.PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_opcode     (in_opcode),
  .in_operand    (in_operand),
  .in_pc         (in_pc),
  .stage_vld     (stage_vld),
  .ev_hole       (ev_hole),
  .ev_group_dead (ev_group_dead),
  .out_done      (out_done),
  .out_kind      (out_kind),
  .out_index     (out_index),
  .trap_req      (trap_req),
  .trap_kind     (trap_kind),
  .trap_param    (trap_param),
  .out_pc        (out_pc)
);

// File: tb/sim_esc_dispatch_decoder.sv
module sim_esc_dispatch_decoder;

  localparam int PCW = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [7:0]     in_opcode = '0;
  logic [7:0]     in_operand = '0;
  logic [PCW-1:0] in_pc = '0;
  logic           out_done;
  logic [1:0]     out_kind;
  logic [7:0]     out_index;
  logic           trap_req;
  logic           trap_kind;
  logic [8:0]     trap_param;
  logic [PCW-1:0] out_pc;

  always #2.5 clk = ~clk;

  esc_dispatch_decoder #(.PC_W(PCW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_operand(in_operand), .in_pc(in_pc), .out_done(out_done),
    .out_kind(out_kind), .out_index(out_index), .trap_req(trap_req),
    .trap_kind(trap_kind), .trap_param(trap_param), .out_pc(out_pc)
  );

  typedef struct packed {
    logic [31:0]    tag;
    int             due;
    logic [1:0]     kind;
    logic [7:0]     idx;
    logic           trap;
    logic           tk;
    logic [8:0]     param;
    logic [PCW-1:0] pc;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input logic [31:0] tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic exp_t model(input logic [7:0] op, input logic [7:0] sub,
                                 input logic [PCW-1:0] pc, input logic [31:0] tag);
    exp_t e;
    bit live, hole;
    e = '0;
    e.tag = tag;
    if (op == 8'hF8 || op == 8'hF9) begin
      live = ((16'h0387 >> sub[7:4]) & 16'h1) != 0;
      hole = (sub == 8'h00) || (sub == 8'h01) || (sub == 8'h2C) || (sub == 8'h2D) ||
             (sub == 8'h2E) || (sub == 8'h7F) || (sub == 8'h83);
      if (live && !hole) begin
        e.kind = 2'b01; e.idx = sub; e.pc = pc + 16'd2;
      end else begin
        e.kind = 2'b11; e.trap = 1'b1; e.tk = 1'b0;
        e.param = 9'h100 + {1'b0, sub}; e.pc = pc + 16'd1;
      end
    end else if (op == 8'h3E || op == 8'h3F || op == 8'h7D || op == 8'h7E ||
                 op == 8'h7F || op == 8'hBF || (op >= 8'hFA && op <= 8'hFE)) begin
      e.kind = 2'b11; e.trap = 1'b1; e.tk = 1'b1;
      e.param = {1'b0, op}; e.pc = pc;
    end else begin
      e.kind = 2'b10; e.pc = pc;
    end
    return e;
  endfunction

  exp_t last_exp;

  // Driver: called at a negedge, leaves in_valid high for one cycle
  task automatic send(input logic [7:0] op, input logic [7:0] sub,
                      input logic [PCW-1:0] pc, input logic [31:0] tag);
    exp_t e;
    e = model(op, sub, pc, tag);
    e.due = cyc + 2;
    q.push_back(e);
    last_exp = e;
    in_opcode = op; in_operand = sub; in_pc = pc; in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && q[0].due < cyc) begin
        chk(1'b0, "R10", "missing done", 0, 1);
        void'(q.pop_front());
      end
      if (out_done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.due == cyc, "R10", "done cycle", cyc, e.due);
          chk(out_kind == e.kind, e.tag, "kind", out_kind, e.kind);
          chk(trap_req == e.trap, e.tag, "trap_req", trap_req, e.trap);
          if (e.trap) chk(trap_kind == e.tk, "R7", "trap_kind", trap_kind, e.tk);
          chk(trap_param == e.param, e.tag, "param", trap_param, e.param);
          chk(out_index == e.idx, e.tag, "index", out_index, e.idx);
          chk(out_pc == e.pc, e.tag, "pc", out_pc, e.pc);
        end
      end
    end
  end

  task automatic check_cleared(input string when);
    chk(out_kind == 2'b00, "R11", {when, " kind"}, out_kind, 0);
    chk(!trap_req && !out_done, "R11", {when, " flags"}, {trap_req, out_done}, 0);
    chk(out_pc == '0 && trap_param == '0 && out_index == '0, "R11", {when, " data"},
        out_pc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_cleared("after reset");

    // R1: both escapes, same sub-opcodes, dispatch and trap cases
    send(8'hF8, 8'h05, 16'h1000, "R1");
    send(8'hF9, 8'h05, 16'h1000, "R1");
    send(8'hF8, 8'h95, 16'h2000, "R8");
    send(8'hF9, 8'h10, 16'h2002, "R8");
    send(8'hF8, 8'h2F, 16'h3000, "R8");
    send(8'hF9, 8'h72, 16'h3004, "R8");
    idle(3);

    // R2: dead groups, first/last codes
    send(8'hF8, 8'h30, 16'h4000, "R2");
    send(8'hF9, 8'h6F, 16'h4010, "R2");
    send(8'hF8, 8'hA0, 16'h4020, "R2");
    send(8'hF9, 8'hFF, 16'h4030, "R2");
    send(8'hF8, 8'h4C, 16'h4040, "R2");
    idle(3);

    // R3/R4: holes inside live groups
    foreach (q[i]) ;
    send(8'hF8, 8'h00, 16'h5000, "R3");
    send(8'hF9, 8'h01, 16'h5002, "R3");
    send(8'hF8, 8'h2C, 16'h5004, "R3");
    send(8'hF9, 8'h2D, 16'h5006, "R4");
    send(8'hF8, 8'h2E, 16'h5008, "R4");
    send(8'hF9, 8'h7F, 16'h500A, "R3");
    send(8'hF8, 8'h83, 16'h500C, "R3");
    send(8'hF8, 8'h84, 16'h500E, "R3");
    idle(3);

    // R5: PC wrap on escape trap and on dispatch
    send(8'hF8, 8'hB1, 16'hFFFF, "R5");
    send(8'hF9, 8'h20, 16'hFFFF, "R8");
    send(8'hF8, 8'h20, 16'hFFFE, "R8");
    idle(3);

    // R6/R7: unimplemented single-byte opcodes
    send(8'h3E, 8'h55, 16'h6000, "R6");
    send(8'h3F, 8'h55, 16'h6001, "R6");
    send(8'h7D, 8'h00, 16'h6002, "R6");
    send(8'h7E, 8'h00, 16'h6003, "R6");
    send(8'h7F, 8'h00, 16'h6004, "R6");
    send(8'hBF, 8'h00, 16'h6005, "R7");
    for (int k = 8'hFA; k <= 8'hFE; k++) send(k[7:0], 8'h11, PCW'(16'h6100 + k), "R6");
    idle(3);

    // R9: ordinary opcodes next to the special codes
    send(8'hF7, 8'h05, 16'h7000, "R9");
    send(8'hFF, 8'h05, 16'h7001, "R9");
    send(8'h00, 8'h00, 16'h7002, "R9");
    send(8'h3D, 8'h2C, 16'h7003, "R9");
    send(8'h40, 8'h00, 16'h7004, "R9");
    send(8'hBE, 8'h30, 16'h7005, "R9");
    idle(3);

    // R10: outputs hold between results
    send(8'hF8, 8'h91, 16'h8000, "R10");
    idle(6);
    chk(out_kind == last_exp.kind && out_index == 8'h91 && !out_done, "R10",
        "hold kind/index", {out_kind, out_index}, {2'b01, 8'h91});
    chk(out_pc == 16'h8002, "R10", "hold pc", out_pc, 16'h8002);

    // R11: reset mid-flight drops pending work
    send(8'hFA, 8'h00, 16'h9000, "R11");
    in_valid = 1'b0;
    rst = 1'b1;
    q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_cleared("mid reset");
    idle(4);
    check_cleared("after flush");

    idle(2);
    chk(q.size() == 0, "R10", "pending results", q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule